// File: doc/BRIEF.md
# Framebuffer Scanout Address Generator

This block produces the memory read requests that fetch one frame for a display pipeline, one line at a time. A frame-start pulse loads a snapshot of the settings: the address of the first line, the bytes to fetch per line, the byte stride from one line start to the next, and the number of lines, programmed as lines minus one. The generator then walks every line. Each line is split into bursts of a selectable beat count, with 16 as the largest, and each request carries its start address and its length in beats.

A request is held on the request port until the memory side accepts it. The number of accepted requests that have not yet been completed is capped by a programmable limit, and each completion pulse lowers that count by one. The block pulses a line-done output after the last burst of each line is accepted. After the final line it also pulses frame-done and drops its active flag, then stays silent until the next frame-start pulse. Setting changes made while a frame is in flight only take effect at the following frame start.

Top module: `fb_scan_addrgen`

## Requirements
- R1: After reset, req_valid, line_done, frame_done and frame_active are all 0.
- R2: A frame_start pulse while frame_active is 0 samples cfg_base, cfg_line_len, cfg_pitch, cfg_line_cnt_m1, cfg_burst_beats and cfg_max_outst. The first request of the frame is at cfg_base. Later changes to these inputs have no effect until the next accepted frame_start.
- R3: A frame_start pulse while frame_active is 1 is ignored. The running frame's requests are unchanged and frame_active stays 1.
- R4: Within a line, bursts are issued at consecutive addresses, each burst starting where the previous one ended. req_beats counts beats of BEAT_BYTES bytes. Full bursts carry the sampled burst size, and a burst setting of 0 or above MAX_BURST means MAX_BURST.
- R5: The last burst of a line is shortened so that it ends exactly at the line length. A line no longer than one burst is a single request.
- R6: Line n (counting from 0) starts at base + n*pitch, and a frame contains cfg_line_cnt_m1+1 lines.
- R7: Accepted requests minus completion pulses never exceeds the sampled limit. A limit of 0 or above MAX_OUTSTAND means MAX_OUTSTAND. Each cpl pulse frees one slot.
- R8: While req_valid is 1 and req_ready is 0, req_valid, req_addr and req_beats hold their values.
- R9: line_done pulses for one cycle in the cycle after the last burst of a line is accepted. On the last line, frame_done pulses in that same cycle and frame_active falls to 0.
- R10: After the final request of a frame is accepted, no request is issued until the next frame_start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Frame start pulse |
| cfg_base | input | ADDR_W | Byte address of the first line |
| cfg_line_len | input | LEN_W | Bytes fetched per line (non-zero multiple of BEAT_BYTES) |
| cfg_pitch | input | LEN_W | Byte stride between line starts |
| cfg_line_cnt_m1 | input | LINE_W | Number of lines minus one |
| cfg_burst_beats | input | BEAT_W | Beats per full burst (0 or >MAX_BURST selects MAX_BURST) |
| cfg_max_outst | input | OUT_W | Outstanding request limit (0 or >MAX_OUTSTAND selects MAX_OUTSTAND) |
| req_valid | output | 1 | Request present |
| req_ready | input | 1 | Memory side accepts the request |
| req_addr | output | ADDR_W | Request start byte address |
| req_beats | output | BEAT_W | Request length in beats |
| cpl | input | 1 | One outstanding request has completed |
| line_done | output | 1 | Last burst of a line accepted (one-cycle pulse) |
| frame_done | output | 1 | Last burst of the frame accepted (one-cycle pulse) |
| frame_active | output | 1 | A frame is being fetched |

## Verification
The bench targets four kinds of corner case. The first is lines whose length is not a multiple of the burst: a design that got this wrong would overrun into the line gap or drop the tail beats. The second is a pitch larger than the line length, where an address counter that forgets the stride would fetch the gap bytes. The third is a limit of one outstanding request under irregular ready and completion traffic: a miscounting tracker would issue past the cap or stall forever. The fourth is configuration and frame_start activity in the middle of a frame: a block that takes the new base early would fetch from the wrong place, and a block that honours the extra pulse would restart the frame. The out-of-range burst and limit encodings, single-line frames, and silence after the final line are also checked.

// File: rtl/fbs_pkg.sv
package fbs_pkg;
  parameter int unsigned FBS_BEAT_BYTES_DEF = 8;
  parameter int unsigned FBS_MAX_BURST_DEF  = 16;
  parameter int unsigned FBS_MAX_OUT_DEF    = 8;

  // Position flags carried alongside each presented request
  typedef struct packed {
    logic eol;  // last burst of its line
    logic eof;  // last burst of the frame
  } fbs_tag_t;
endpackage

// File: rtl/fbs_outstanding.sv
module fbs_outstanding #(
  parameter int MAX_OUTSTAND = 8,
  localparam int OUT_W = $clog2(MAX_OUTSTAND + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue,   // request accepted this cycle
  input  logic             retire,  // completion returned this cycle
  input  logic [OUT_W-1:0] limit,
  output logic [OUT_W-1:0] count,
  output logic             room     // another request may be presented
);
  logic [OUT_W:0] after_issue;

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else if (issue && !retire) count <= count + 1'b1;
    else if (!issue && retire) count <= count - 1'b1;
  end

  // Completions in flight are not credited, which keeps the check conservative
  assign after_issue = {1'b0, count} + {{OUT_W{1'b0}}, issue};
  assign room        = after_issue < {1'b0, limit};
endmodule

// File: rtl/fbs_burst_size.sv
module fbs_burst_size #(
  parameter int LEN_W      = 16,
  parameter int BEAT_BYTES = 8,
  parameter int MAX_BURST  = 16,
  localparam int BEAT_W  = $clog2(MAX_BURST + 1),
  localparam int BYTE_SH = $clog2(BEAT_BYTES)
) (
  input  logic [LEN_W-1:0]  remain,
  input  logic [BEAT_W-1:0] burst_beats,
  output logic [LEN_W-1:0]  take_bytes,
  output logic [BEAT_W-1:0] take_beats,
  output logic              last
);
  logic [LEN_W-1:0] cap_bytes;
  logic [LEN_W-1:0] beats_wide;

  assign cap_bytes  = LEN_W'(burst_beats) << BYTE_SH;
  assign last       = (remain <= cap_bytes);
  assign take_bytes = last ? remain : cap_bytes;
  assign beats_wide = take_bytes >> BYTE_SH;
  assign take_beats = beats_wide[BEAT_W-1:0];
endmodule

// File: rtl/fb_scan_addrgen.sv
module fb_scan_addrgen
  import fbs_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int LEN_W        = 16,
  parameter int LINE_W       = 12,
  parameter int BEAT_BYTES   = FBS_BEAT_BYTES_DEF,
  parameter int MAX_BURST    = FBS_MAX_BURST_DEF,
  parameter int MAX_OUTSTAND = FBS_MAX_OUT_DEF,
  localparam int BEAT_W = $clog2(MAX_BURST + 1),
  localparam int OUT_W  = $clog2(MAX_OUTSTAND + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [LEN_W-1:0]  cfg_line_len,
  input  logic [LEN_W-1:0]  cfg_pitch,
  input  logic [LINE_W-1:0] cfg_line_cnt_m1,
  input  logic [BEAT_W-1:0] cfg_burst_beats,
  input  logic [OUT_W-1:0]  cfg_max_outst,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic [BEAT_W-1:0] req_beats,
  input  logic              cpl,
  output logic              line_done,
  output logic              frame_done,
  output logic              frame_active
);
  // Frame snapshot
  logic [LEN_W-1:0]  s_len;
  logic [LEN_W-1:0]  s_pitch;
  logic [LINE_W-1:0] s_cnt;
  logic [BEAT_W-1:0] s_burst;
  logic [OUT_W-1:0]  s_lim;

  // Walk state
  logic [ADDR_W-1:0] line_base;
  logic [ADDR_W-1:0] cur_addr;
  logic [LEN_W-1:0]  remain;
  logic [LINE_W-1:0] line_idx;
  logic              more;
  fbs_tag_t          req_tag;

  logic              accept, load, room, last_burst, start_ok;
  logic [LEN_W-1:0]  take_bytes;
  logic [BEAT_W-1:0] take_beats;
  logic [OUT_W-1:0]  outst_cnt;
  logic [ADDR_W-1:0] next_line;
  logic [BEAT_W-1:0] burst_eff;
  logic [OUT_W-1:0]  lim_eff;

  assign accept    = req_valid && req_ready;
  assign load      = more && (!req_valid || req_ready) && room;
  assign start_ok  = frame_start && !frame_active;
  assign next_line = line_base + ADDR_W'(s_pitch);
  assign burst_eff = (cfg_burst_beats == '0 || 32'(cfg_burst_beats) > MAX_BURST)
                     ? BEAT_W'(MAX_BURST) : cfg_burst_beats;
  assign lim_eff   = (cfg_max_outst == '0 || 32'(cfg_max_outst) > MAX_OUTSTAND)
                     ? OUT_W'(MAX_OUTSTAND) : cfg_max_outst;

  fbs_outstanding #(.MAX_OUTSTAND(MAX_OUTSTAND)) u_outst (
    .clk    (clk),
    .rst    (rst),
    .issue  (accept),
    .retire (cpl),
    .limit  (s_lim),
    .count  (outst_cnt),
    .room   (room)
  );

  fbs_burst_size #(
    .LEN_W      (LEN_W),
    .BEAT_BYTES (BEAT_BYTES),
    .MAX_BURST  (MAX_BURST)
  ) u_burst (
    .remain      (remain),
    .burst_beats (s_burst),
    .take_bytes  (take_bytes),
    .take_beats  (take_beats),
    .last        (last_burst)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s_len        <= '0;
      s_pitch      <= '0;
      s_cnt        <= '0;
      s_burst      <= BEAT_W'(MAX_BURST);
      s_lim        <= OUT_W'(MAX_OUTSTAND);
      line_base    <= '0;
      cur_addr     <= '0;
      remain       <= '0;
      line_idx     <= '0;
      more         <= 1'b0;
      req_valid    <= 1'b0;
      req_addr     <= '0;
      req_beats    <= '0;
      req_tag      <= '0;
      line_done    <= 1'b0;
      frame_done   <= 1'b0;
      frame_active <= 1'b0;
    end else begin
      line_done  <= accept && req_tag.eol;
      frame_done <= accept && req_tag.eof;

      if (start_ok) begin
        s_len        <= cfg_line_len;
        s_pitch      <= cfg_pitch;
        s_cnt        <= cfg_line_cnt_m1;
        s_burst      <= burst_eff;
        s_lim        <= lim_eff;
        line_base    <= cfg_base;
        cur_addr     <= cfg_base;
        remain       <= cfg_line_len;
        line_idx     <= '0;
        more         <= 1'b1;
        frame_active <= 1'b1;
      end else if (accept && req_tag.eof) begin
        frame_active <= 1'b0;
      end

      if (load) begin
        req_valid   <= 1'b1;
        req_addr    <= cur_addr;
        req_beats   <= take_beats;
        req_tag.eol <= last_burst;
        req_tag.eof <= last_burst && (line_idx == s_cnt);
        if (last_burst) begin
          if (line_idx == s_cnt) begin
            more <= 1'b0;
          end else begin
            line_idx  <= line_idx + 1'b1;
            line_base <= next_line;
            cur_addr  <= next_line;
            remain    <= s_len;
          end
        end else begin
          cur_addr <= cur_addr + ADDR_W'(take_bytes);
          remain   <= remain - take_bytes;
        end
      end else if (accept) begin
        req_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fbs_checker.sv
module fbs_checker #(
  parameter int ADDR_W = 32,
  parameter int BEAT_W = 5,
  parameter int OUT_W  = 4,
  parameter int MAX_BURST = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic [BEAT_W-1:0] req_beats,
  input logic              line_done,
  input logic              frame_done,
  input logic              frame_active,
  input logic [OUT_W-1:0]  outst_cnt,
  input logic [OUT_W-1:0]  s_lim
);
  assert_cap_R7: assert property (@(posedge clk) disable iff (rst)
    outst_cnt <= s_lim);

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_beats)));

  assert_line_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    line_done |-> $past(req_valid && req_ready));

  assert_frame_line_R9: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> (line_done && !frame_active));

  assert_req_in_frame_R10: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> frame_active);

  assert_beats_range_R4: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (req_beats != '0 && 32'(req_beats) <= MAX_BURST));
endmodule

bind fb_scan_addrgen fbs_checker #(
  .ADDR_W    (ADDR_W),
  .BEAT_W    (BEAT_W),
  .OUT_W     (OUT_W),
  .MAX_BURST (MAX_BURST)
) u_fbs_checker (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_addr     (req_addr),
  .req_beats    (req_beats),
  .line_done    (line_done),
  .frame_done   (frame_done),
  .frame_active (frame_active),
  .outst_cnt    (outst_cnt),
  .s_lim        (s_lim)
);

// File: tb/test_fb_scan_addrgen.sv
`timescale 1ns/1ps
module test_fb_scan_addrgen;
  localparam int ADDR_W = 32, LEN_W = 16, LINE_W = 12;
  localparam int BB = 8, MB = 16, MO = 8;
  localparam int BEAT_W = $clog2(MB + 1), OUT_W = $clog2(MO + 1);

  typedef struct {
    logic [31:0] a;
    int          beats;
    bit          eol;
    bit          eof;
  } item_t;

  logic clk = 0, rst = 1, frame_start = 0;
  logic [ADDR_W-1:0] cfg_base = '0;
  logic [LEN_W-1:0]  cfg_line_len = '0, cfg_pitch = '0;
  logic [LINE_W-1:0] cfg_line_cnt_m1 = '0;
  logic [BEAT_W-1:0] cfg_burst_beats = '0;
  logic [OUT_W-1:0]  cfg_max_outst = '0;
  logic req_valid, req_ready = 0, cpl = 0;
  logic [ADDR_W-1:0] req_addr;
  logic [BEAT_W-1:0] req_beats;
  logic line_done, frame_done, frame_active;

  int checks = 0, errors = 0;
  item_t q[$];
  int lim_m = MO;
  int out_m = 0;
  bit acc_prev = 0, cpl_prev = 0, pend_eol = 0, pend_eof = 0, frame_seen = 0;
  bit rdy_rand = 0, cpl_rand = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  fb_scan_addrgen i_fb_scan_addrgen (
    .clk(clk), .rst(rst), .frame_start(frame_start),
    .cfg_base(cfg_base), .cfg_line_len(cfg_line_len), .cfg_pitch(cfg_pitch),
    .cfg_line_cnt_m1(cfg_line_cnt_m1), .cfg_burst_beats(cfg_burst_beats),
    .cfg_max_outst(cfg_max_outst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_beats(req_beats), .cpl(cpl),
    .line_done(line_done), .frame_done(frame_done), .frame_active(frame_active));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor and responder: sampled at the falling edge
  always @(negedge clk) begin
    if (!rst) begin
      if (pend_eol || line_done)
        check(line_done == pend_eol, "R9 line_done", line_done, pend_eol);
      if (pend_eof || frame_done) begin
        check(frame_done == pend_eof, "R9 frame_done", frame_done, pend_eof);
        check(frame_active == 1'b0, "R9 frame_active falls", frame_active, 0);
      end
      if (frame_done) frame_seen = 1;
      out_m = out_m + int'(acc_prev) - int'(cpl_prev);
      if (acc_prev)
        check(out_m <= lim_m, "R7 outstanding cap", out_m, lim_m);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      req_ready = rdy_rand ? lfsr[3] : 1'b1;
      cpl = (out_m > 0) && (cpl_rand ? (lfsr[7] & lfsr[1]) : 1'b1);
      cpl_prev = cpl;
      acc_prev = req_valid && req_ready;
      pend_eol = 0;
      pend_eof = 0;
      if (acc_prev) begin
        if (q.size() == 0) begin
          check(0, "R10 unexpected request", req_addr, 0);
        end else begin
          item_t e;
          e = q.pop_front();
          check(req_addr == e.a, "R4/R6 request address", req_addr, e.a);
          check(int'(req_beats) == e.beats, "R5 request beats", req_beats, e.beats);
          pend_eol = e.eol;
          pend_eof = e.eof;
        end
      end
    end
  end

  // Driver: computes the expected request stream and starts the frame
  task automatic start_frame(input logic [31:0] base, input int len, input int pitch,
                             input int cnt_m1, input int burst, input int lim);
    int cap;
    cap = (burst == 0 || burst > MB) ? MB : burst;
    for (int l = 0; l <= cnt_m1; l++) begin
      logic [31:0] a;
      int rem;
      a = base + 32'(l * pitch);
      rem = len;
      while (rem > 0) begin
        item_t it;
        int take;
        take = (rem <= cap * BB) ? rem : cap * BB;
        it.a = a; it.beats = take / BB;
        it.eol = (rem <= cap * BB);
        it.eof = it.eol && (l == cnt_m1);
        q.push_back(it);
        a += 32'(take);
        rem -= take;
      end
    end
    @(negedge clk);
    cfg_base = base; cfg_line_len = LEN_W'(len); cfg_pitch = LEN_W'(pitch);
    cfg_line_cnt_m1 = LINE_W'(cnt_m1); cfg_burst_beats = BEAT_W'(burst);
    cfg_max_outst = OUT_W'(lim);
    lim_m = (lim == 0 || lim > MO) ? MO : lim;
    frame_seen = 0;
    frame_start = 1;
    @(negedge clk);
    frame_start = 0;
  endtask

  task automatic wait_frame(input string req);
    while (!frame_seen) @(negedge clk);
    check(q.size() == 0, req, q.size(), 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    check(req_valid == 0 && line_done == 0 && frame_done == 0 && frame_active == 0,
          "R1 reset outputs", {req_valid, line_done, frame_done, frame_active}, 0);

    // R4 R6: pitch larger than the line, two full bursts per line
    start_frame(32'h0000_1000, 256, 512, 3, 16, 4);
    wait_frame("R6 all lines fetched");

    // R5 R7: shortened tail, single outstanding, irregular traffic
    rdy_rand = 1; cpl_rand = 1;
    start_frame(32'h8000_0040, 200, 200, 2, 8, 1);
    wait_frame("R5 frame with short tail");

    // R4 R5: burst 0 selects maximum, line shorter than one burst, one line
    start_frame(32'h0000_4000, 24, 24, 0, 0, 0);
    wait_frame("R5 single short burst");

    // R3 R2: mid-frame changes and an extra pulse are ignored
    start_frame(32'h0000_2000, 128, 256, 5, 4, 2);
    repeat (6) @(negedge clk);
    cfg_base = 32'h0000_9000; cfg_line_len = 16'd64; cfg_pitch = 16'd64;
    cfg_line_cnt_m1 = 12'd1; cfg_burst_beats = 5'd16; cfg_max_outst = 4'd3;
    frame_start = 1;
    @(negedge clk);
    frame_start = 0;
    check(frame_active == 1, "R3 frame_active held", frame_active, 1);
    wait_frame("R3 running frame unchanged");

    // R10: silence after the final line
    begin
      bit quiet = 1;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (req_valid) quiet = 0;
      end
      check(quiet, "R10 no request after frame", !quiet, 0);
    end

    // R2: next frame uses the new base sampled at its start
    rdy_rand = 0; cpl_rand = 0;
    start_frame(32'h0000_9000, 64, 64, 1, 16, 3);
    wait_frame("R2 new base taken at frame start");

    // R4: out-of-range burst setting selects maximum
    rdy_rand = 1;
    start_frame(32'h0001_0000, 384, 1024, 1, 20, 9);
    wait_frame("R4 oversize burst setting");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule